// File: doc/BRIEF.md
# Real-Time Clock Core with Host Access Hold

This block keeps time of day. It holds a hundredths-of-second counter driven by a 100 Hz tick, and BCD seconds, minutes and hours counters that take the carry from it. The host reaches the block through a simple register port: an address, a write strobe with write data, and read data that is combinational on the address. A chip-enable input marks the span of one host transaction.

While chip enable is high, the visible copies of seconds, minutes and hours stay frozen. A multi-byte read therefore cannot tear across a carry. The internal counters keep running, and the visible copy catches up one clock after chip enable falls. The hundredths register is not frozen. It always returns the live count. As a result, a read that crosses a second boundary can pair fresh hundredths with seconds that are one second old. Host software can detect that case in two ways. It can read hundredths twice, or it can check an update flag. The flag is set each second, or each minute, depending on a control bit.

Top module: `rtc_hold_core`

## Requirements
- R1: After reset, the hundredths (0x0), seconds (0x1), minutes (0x2) and hours (0x3) registers all read 0x00. The control register 0xD and the flag register 0xE also read 0x00.
- R2: Each cycle with the tick high advances hundredths in BCD (0x09 goes to 0x10). 0x99 wraps to 0x00 and adds one to seconds.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00.
- R4: While chip enable is high, reads of 0x1 to 0x3 return the values that were visible when chip enable rose. Ticks and carries do not change them.
- R5: Reads of 0x0 return the live hundredths count at all times, including while chip enable is high.
- R6: Time advances internally during a hold. One clock after chip enable is seen low, reads of 0x1 to 0x3 show the current internal time.
- R7: With bit 0 of register 0xD at 0, bit 0 of register 0xE is set in the same cycle that seconds advance.
- R8: With bit 0 of register 0xD at 1, bit 0 of register 0xE is set only when minutes advance. A seconds advance without a minute carry leaves it at 0.
- R9: Writing 0 to bit 0 of register 0xE clears the flag. Writing 1 has no effect. A set event in the same cycle as a clearing write leaves the flag at 1.
- R10: A write to 0x0 to 0x3 loads that counter. Seconds and minutes keep bits 6:0, and hours keep bits 5:0. Only bit 0 of 0xD is stored. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100hz_i | input | 1 | One-cycle pulse at 100 Hz that advances hundredths |
| host_ce_i | input | 1 | High during a host transaction; freezes visible time |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational on addr_i |

## Verification
A tick or counter write lands at the next rising edge. The live hundredths value and the update flag are therefore due one clock after the stimulus. The visible seconds, minutes and hours are copied from the internal counters one edge later, so they are due two clocks after a write or tick when chip enable is low. After chip enable falls, the visible registers are due exactly one clock later. The bench drives every input at a falling edge and reads at the next falling edge. Before any visible-time check, it waits one extra falling edge. Right after releasing chip enable, it checks both the still-frozen value and the caught-up value one clock later.

// File: rtl/rtc_hold_pkg.sv
// Package: shared constants and BCD helpers for the RTC hold core.
// Assumes four counter stages ordered hundredths, seconds, minutes, hours.
package rtc_hold_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int NUM_STAGES = 4;
    localparam int NUM_TIME   = NUM_STAGES - 1;

    localparam logic [ADDR_W-1:0] ADDR_HUN  = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_SEC  = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_MIN  = 4'h2;
    localparam logic [ADDR_W-1:0] ADDR_HR   = 4'h3;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'hD;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 4'hE;

    typedef logic [DATA_W-1:0] bcd_byte_t;

    // Upper limit of each stage in BCD.
    function automatic bcd_byte_t stage_max(input int idx);
        case (idx)
            0:       return 8'h99;
            1:       return 8'h59;
            2:       return 8'h59;
            default: return 8'h23;
        endcase
    endfunction

    // Bits kept when the host writes a stage.
    function automatic bcd_byte_t stage_mask(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'h7F;
            2:       return 8'h7F;
            default: return 8'h3F;
        endcase
    endfunction

    // Two-digit BCD increment (the caller handles the wrap).
    function automatic bcd_byte_t bcd_inc(input bcd_byte_t v);
        bcd_byte_t r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_bcd_stage.sv
// Module: one two-digit BCD counter stage with a host load.
// Counts from 0 to MAX_VAL on inc_i and raises carry_o in the wrap cycle.
// A load has priority over an increment in the same cycle and suppresses
// the carry. Assumes the loaded value is valid BCD.
module rtc_bcd_stage
    import rtc_hold_pkg::*;
#(
    parameter logic [DATA_W-1:0] MAX_VAL    = 8'h59,
    parameter logic [DATA_W-1:0] FIELD_MASK = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              ld_i,
    input  logic [DATA_W-1:0] ld_val_i,
    output logic [DATA_W-1:0] val_o,
    output logic              carry_o
);

    logic [DATA_W-1:0] val_q;
    logic              at_max;

    assign at_max = (val_q == MAX_VAL);

    // Counter register: reset, then host load, then increment with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (ld_i) begin
            val_q <= ld_val_i & FIELD_MASK;
        end else if (inc_i) begin
            val_q <= at_max ? '0 : bcd_inc(val_q);
        end
    end

    // Carry out to the next stage when this stage wraps.
    always_comb begin
        carry_o = inc_i & ~ld_i & at_max;
    end

    assign val_o = val_q;

endmodule

// File: rtl/rtc_time_chain.sv
// Module: chain of BCD stages for hundredths, seconds, minutes and hours.
// Stage 0 advances on the tick. Each later stage advances on the carry
// of the stage before it.
module rtc_time_chain
    import rtc_hold_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick_i,
    input  logic [NUM_STAGES-1:0]             ld_vec_i,
    input  logic [DATA_W-1:0]                 ld_val_i,
    output logic [NUM_STAGES-1:0][DATA_W-1:0] count_o,
    output logic [NUM_STAGES-1:0]             carry_o
);

    logic [NUM_STAGES:0] inc_chain;

    // Increment source of stage 0 is the 100 Hz tick.
    always_comb begin
        inc_chain[0] = tick_i;
    end

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        rtc_bcd_stage #(
            .MAX_VAL    (stage_max(i)),
            .FIELD_MASK (stage_mask(i))
        ) stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (inc_chain[i]),
            .ld_i     (ld_vec_i[i]),
            .ld_val_i (ld_val_i),
            .val_o    (count_o[i]),
            .carry_o  (carry_o[i])
        );
        assign inc_chain[i+1] = carry_o[i];
    end

endmodule

// File: rtl/rtc_hold_mirror.sv
// Module: visible copy of seconds, minutes and hours.
// Follows the live time one clock behind while hold_i is low and freezes
// while it is high. Assumes hold_i is synchronous to clk.
module rtc_hold_mirror
    import rtc_hold_pkg::*;
#(
    parameter int NUM = NUM_TIME
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hold_i,
    input  logic [NUM-1:0][DATA_W-1:0] live_i,
    output logic [NUM-1:0][DATA_W-1:0] vis_o
);

    logic [NUM-1:0][DATA_W-1:0] vis_q;

    // Copy the live time whenever no host transaction is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q <= '0;
        end else if (!hold_i) begin
            vis_q <= live_i;
        end
    end

    assign vis_o = vis_q;

endmodule

// File: rtl/rtc_update_flag.sv
// Module: update-period select bit and sticky update flag.
// The flag is set on a seconds advance (sel = 0) or a minutes advance
// (sel = 1). Writing 0 clears it; a set in the same cycle wins.
module rtc_update_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_evt_i,
    input  logic min_evt_i,
    input  logic sel_wr_i,
    input  logic sel_val_i,
    input  logic flag_clr_i,
    output logic sel_o,
    output logic flag_o
);

    logic sel_q;
    logic flag_q;
    logic set_evt;

    // Pick the event that matches the selected period.
    always_comb begin
        set_evt = sel_q ? min_evt_i : sec_evt_i;
    end

    // Period select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (sel_wr_i) begin
            sel_q <= sel_val_i;
        end
    end

    // Sticky flag: a set takes priority over a host clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (flag_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign sel_o  = sel_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/rtc_hold_core.sv
// Module: top of the RTC core with host access hold.
// Decodes host writes, runs the counter chain, keeps the frozen visible
// time and drives the read mux. Reads are combinational on addr_i.
// Assumes all inputs are synchronous to clk.
module rtc_hold_core
    import rtc_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz_i,
    input  logic              host_ce_i,
    input  logic              wr_en_i,
    input  logic [3:0]        addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o
);

    logic [NUM_STAGES-1:0][DATA_W-1:0] count;
    logic [NUM_STAGES-1:0]             carry;
    logic [NUM_STAGES-1:0]             ld_vec;
    logic [NUM_TIME-1:0][DATA_W-1:0]   live_time;
    logic [NUM_TIME-1:0][DATA_W-1:0]   vis_time;
    logic                              sel_wr;
    logic                              flag_clr;
    logic                              upd_sel;
    logic                              upd_flag;

    // Write decode for the counter stages.
    always_comb begin
        for (int i = 0; i < NUM_STAGES; i++) begin
            ld_vec[i] = wr_en_i && (addr_i == ADDR_W'(i));
        end
    end

    // Write decode for the control and flag registers.
    always_comb begin
        sel_wr   = wr_en_i && (addr_i == ADDR_CTRL);
        flag_clr = wr_en_i && (addr_i == ADDR_FLAG) && !wdata_i[0];
    end

    rtc_time_chain chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_100hz_i),
        .ld_vec_i (ld_vec),
        .ld_val_i (wdata_i),
        .count_o  (count),
        .carry_o  (carry)
    );

    assign live_time = count[NUM_STAGES-1:1];

    rtc_hold_mirror #(.NUM(NUM_TIME)) mirror_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (host_ce_i),
        .live_i (live_time),
        .vis_o  (vis_time)
    );

    rtc_update_flag flag_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_evt_i  (carry[0]),
        .min_evt_i  (carry[1]),
        .sel_wr_i   (sel_wr),
        .sel_val_i  (wdata_i[0]),
        .flag_clr_i (flag_clr),
        .sel_o      (upd_sel),
        .flag_o     (upd_flag)
    );

    // Read mux: live hundredths, frozen time, control and flag bits.
    always_comb begin
        case (addr_i)
            ADDR_HUN:  rdata_o = count[0];
            ADDR_SEC:  rdata_o = vis_time[0];
            ADDR_MIN:  rdata_o = vis_time[1];
            ADDR_HR:   rdata_o = vis_time[2];
            ADDR_CTRL: rdata_o = {7'd0, upd_sel};
            ADDR_FLAG: rdata_o = {7'd0, upd_flag};
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/rtc_hold_core_chk.sv
// Module: assertion checker bound to rtc_hold_core.
// Observes the counter chain, the visible copy and the update flag.
module rtc_hold_core_chk (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_100hz_i,
    input logic             host_ce_i,
    input logic             wr_en_i,
    input logic [3:0][7:0]  count,
    input logic [3:0]       carry,
    input logic [2:0][7:0]  live_time,
    input logic [2:0][7:0]  vis_time,
    input logic             upd_sel,
    input logic             upd_flag
);

    // R2: the hundredths stage reads 0 right after its wrap.
    assert_hun_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        carry[0] |=> (count[0] == 8'h00));

    // R3: the seconds stage reads 0 right after its wrap.
    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        carry[1] |=> (live_time[0] == 8'h00));

    // R4: the visible time does not move after a held cycle.
    assert_vis_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_ce_i) |-> $stable(vis_time));

    // R5: hundredths change on every tick that comes without a write.
    assert_hun_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_100hz_i && !wr_en_i) |=> (count[0] != $past(count[0])));

    // R6: with no hold, the visible copy trails the live time by one clock.
    assert_catchup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ce_i |=> (vis_time == $past(live_time)));

    // R7: in per-second mode, a seconds advance sets the flag.
    assert_flag_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_sel && carry[0]) |=> upd_flag);

    // R8: in per-minute mode, a minutes advance sets the flag.
    assert_flag_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_sel && carry[1]) |=> upd_flag);

endmodule

bind rtc_hold_core rtc_hold_core_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_100hz_i (tick_100hz_i),
    .host_ce_i    (host_ce_i),
    .wr_en_i      (wr_en_i),
    .count        (count),
    .carry        (carry),
    .live_time    (live_time),
    .vis_time     (vis_time),
    .upd_sel      (upd_sel),
    .upd_flag     (upd_flag)
);

// File: tb/rtc_hold_core_tb_top.sv
// Directed bench for rtc_hold_core: one task per scenario.
module rtc_hold_core_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ce = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_hold_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_100hz_i (tick),
        .host_ce_i    (ce),
        .wr_en_i      (wr),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] hr, input logic [7:0] mn,
                            input logic [7:0] sc, input logic [7:0] hu);
        do_write(4'h3, hr);
        do_write(4'h2, mn);
        do_write(4'h1, sc);
        do_write(4'h0, hu);
        settle();
    endtask

    task automatic test_reset();
        expect_reg("R1 hundredths", 4'h0, 8'h00);
        expect_reg("R1 seconds",    4'h1, 8'h00);
        expect_reg("R1 minutes",    4'h2, 8'h00);
        expect_reg("R1 hours",      4'h3, 8'h00);
        expect_reg("R1 control",    4'hD, 8'h00);
        expect_reg("R1 flag",       4'hE, 8'h00);
    endtask

    task automatic test_hundredths();
        for (int i = 0; i < 12; i++) do_tick();
        expect_reg("R2 bcd count 12", 4'h0, 8'h12);
        do_write(4'h0, 8'h98);
        do_tick();
        expect_reg("R2 reach 99", 4'h0, 8'h99);
        do_tick();
        expect_reg("R2 wrap to 00", 4'h0, 8'h00);
        settle();
        expect_reg("R2 carry to seconds", 4'h1, 8'h01);
    endtask

    task automatic test_wrap();
        set_time(8'h23, 8'h59, 8'h59, 8'h99);
        do_tick();
        settle();
        expect_reg("R3 hours wrap",   4'h3, 8'h00);
        expect_reg("R3 minutes wrap", 4'h2, 8'h00);
        expect_reg("R3 seconds wrap", 4'h1, 8'h00);
        set_time(8'h05, 8'h12, 8'h59, 8'h99);
        do_tick();
        settle();
        expect_reg("R3 minute carry", 4'h2, 8'h13);
        expect_reg("R3 hour kept",    4'h3, 8'h05);
        do_write(4'h1, 8'hFF);
        do_write(4'h3, 8'hFF);
        settle();
        expect_reg("R10 seconds mask", 4'h1, 8'h7F);
        expect_reg("R10 hours mask",   4'h3, 8'h3F);
    endtask

    task automatic test_hold();
        set_time(8'h10, 8'h20, 8'h10, 8'h97);
        @(negedge clk);
        ce = 1'b1;
        for (int i = 0; i < 3; i++) do_tick();
        settle();
        expect_reg("R5 hundredths live in hold", 4'h0, 8'h00);
        expect_reg("R4 seconds held",            4'h1, 8'h10);
        expect_reg("R4 minutes held",            4'h2, 8'h20);
        @(negedge clk);
        ce = 1'b0;
        #1;
        expect_reg("R6 still frozen at release", 4'h1, 8'h10);
        @(negedge clk);
        expect_reg("R6 caught up one clock later", 4'h1, 8'h11);
        ce = 1'b1;
        for (int i = 0; i < 100; i++) do_tick();
        expect_reg("R5 hundredths after 100 ticks", 4'h0, 8'h00);
        expect_reg("R4 seconds held across rollover", 4'h1, 8'h11);
        @(negedge clk);
        ce = 1'b0;
        @(negedge clk);
        expect_reg("R6 seconds after release", 4'h1, 8'h12);
    endtask

    task automatic test_flag();
        do_write(4'hD, 8'h00);
        do_write(4'hE, 8'h00);
        expect_reg("R9 flag cleared", 4'hE, 8'h00);
        do_write(4'h0, 8'h50);
        do_tick();
        expect_reg("R7 no set without second", 4'hE, 8'h00);
        do_write(4'h0, 8'h99);
        do_tick();
        expect_reg("R7 set on second", 4'hE, 8'h01);
        do_write(4'hE, 8'hFF);
        expect_reg("R9 write one ignored", 4'hE, 8'h01);
        do_write(4'hE, 8'h00);
        expect_reg("R9 write zero clears", 4'hE, 8'h00);
        do_write(4'h0, 8'h99);
        @(negedge clk);
        tick = 1'b1; wr = 1'b1; addr = 4'hE; wdata = 8'h00;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0;
        expect_reg("R9 set wins over clear", 4'hE, 8'h01);
    endtask

    task automatic test_minute_sel();
        do_write(4'hD, 8'h01);
        expect_reg("R8 select reads back", 4'hD, 8'h01);
        do_write(4'hE, 8'h00);
        set_time(8'h01, 8'h02, 8'h30, 8'h99);
        do_tick();
        expect_reg("R8 no set on plain second", 4'hE, 8'h00);
        set_time(8'h01, 8'h02, 8'h59, 8'h99);
        do_tick();
        expect_reg("R8 set on minute", 4'hE, 8'h01);
        do_write(4'hD, 8'hFE);
        expect_reg("R10 control keeps bit 0 only", 4'hD, 8'h00);
    endtask

    task automatic test_unmapped();
        expect_reg("R10 unmapped 0x7", 4'h7, 8'h00);
        expect_reg("R10 unmapped 0xF", 4'hF, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_hundredths();
        test_wrap();
        test_hold();
        test_flag();
        test_minute_sel();
        test_unmapped();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule